// File: doc/BRIEF.md
# Serial DAC Command and Power-Down Controller

This block is the control core of a 10-bit serial voltage DAC. A two-wire slave front end hands it received bytes one at a time, along with pulses that mark a new frame, a bus stop and the falling clock edge that closes each acknowledge slot. The block pairs the bytes into a two-byte write frame. The upper nibble of the first byte is a 4-bit command, and the remaining ten payload bits carry either a DAC code or a power-down selection. The two unused low bits of the second byte are always zero.

Two 10-bit registers are held. A staging (input) register can be loaded without disturbing the output. A live (DAC) register drives the converter code. A 2-bit mode register selects either normal drive or one of three power-down output conditions. Nothing commits until the acknowledge falling edge that follows the second byte, so a frame that is cut short leaves all state untouched. The block also presents a two-byte read-back image of the live register and the mode for the front end to shift out.

Top module: `dac_cmd_core`

## Requirements
- R1: After reset, the staging and live registers are 0, the mode is 11, `term_100k_o`=1, and `buf_en_o`=0.
- R2: Command 1100 writes the payload code into both registers, so `dac_code_o` changes on commit. The code is first byte bits 3:0 as code bits 9:6, then second byte bits 7:2 as code bits 5:0.
- R3: Command 1101 writes the payload into the staging register only. `dac_code_o` keeps its value.
- R4: Command 1110 writes the payload into the staging register and moves the old staging value into the live register.
- R5: Command 1111 copies the staging register into the live register and ignores the payload.
- R6: Commands 0100 to 0111 set the mode from first byte bits 3:2 (bit 3 is the upper mode bit). Neither code register changes.
- R7: Mode decode: 00 gives `buf_en_o`=1 and both terminations off. 01 turns all three off (floating). 10 gives `term_1k_o`=1. 11 gives `term_100k_o`=1.
- R8: Both registers keep their contents through power-down and can be loaded while powered down. Returning to mode 00 drives the retained code.
- R9: A commit happens only on `ack_fall_i` after the second byte of a frame. A `start_i` or `stop_i` before that edge drops the partial frame. An `ack_fall_i` after only one byte changes nothing.
- R10: `rb_hi_o` = {00, mode, live[9:6]} and `rb_lo_o` = {live[5:0], 00}.
- R11: Commands 0000 to 0011 (0001 is the read request) and 1000 to 1011 change no state.
- R12: Back-to-back frames with no `start_i` between them are each decoded and committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset |
| start_i | input | 1 | Pulse: new addressed write frame begins |
| stop_i | input | 1 | Pulse: bus stop or abort |
| rx_valid_i | input | 1 | Pulse: `rx_byte_i` holds a received byte |
| rx_byte_i | input | 8 | Received byte, MSB first as sent |
| ack_fall_i | input | 1 | Pulse: clock falling edge ending an acknowledge slot |
| dac_code_o | output | 10 | Live converter code |
| buf_en_o | output | 1 | Output amplifier enable |
| term_1k_o | output | 1 | Select 1 kΩ output termination |
| term_100k_o | output | 1 | Select 100 kΩ output termination |
| rb_hi_o | output | 8 | Read-back byte 1 |
| rb_lo_o | output | 8 | Read-back byte 2 |

## Verification
On every cycle, the assertions check four things: no register moves without a completed frame's acknowledge edge, power-mode and ignored commands leave both code registers alone, at most one output condition is selected, and the read-back filler bits are zero. Some behaviours show up only across a sequence of frames, so the bench scenarios must cover them. These are the deferred transfer of the old staging value, the code retained across a power-down and wake, abort handling, and back-to-back frames. A behavioural model in the bench tracks all of these and is compared with every output on each clock.

// File: rtl/dac_cmd_core.sv
module dac_cmd_core #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              ack_fall_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              buf_en_o,
  output logic              term_1k_o,
  output logic              term_100k_o,
  output logic [7:0]        rb_hi_o,
  output logic [7:0]        rb_lo_o
);
  localparam int HI_W = CODE_W - 6;

  logic [1:0]        cnt_q;
  logic [7:0]        b0_q, b1_q;
  logic [CODE_W-1:0] in_q, dac_q;
  logic [1:0]        pd_q;

  logic [3:0]        cmd;
  logic [CODE_W-1:0] payload;
  logic              commit;

  assign cmd     = b0_q[7:4];
  assign payload = {b0_q[HI_W-1:0], b1_q[7:2]};
  assign commit  = ack_fall_i && (cnt_q == 2'd2) && !start_i && !stop_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= 2'd0;
      b0_q  <= '0;
      b1_q  <= '0;
    end else if (start_i || stop_i) begin
      cnt_q <= 2'd0;
    end else if (rx_valid_i && cnt_q == 2'd0) begin
      b0_q  <= rx_byte_i;
      cnt_q <= 2'd1;
    end else if (rx_valid_i && cnt_q == 2'd1) begin
      b1_q  <= rx_byte_i;
      cnt_q <= 2'd2;
    end else if (commit) begin
      cnt_q <= 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      dac_q <= '0;
      pd_q  <= 2'b11;
    end else if (commit) begin
      casez (cmd)
        4'b1100: begin in_q <= payload; dac_q <= payload; end
        4'b1101: in_q <= payload;
        4'b1110: begin in_q <= payload; dac_q <= in_q; end
        4'b1111: dac_q <= in_q;
        4'b01??: pd_q <= b0_q[3:2];
        default: ;
      endcase
    end
  end

  assign dac_code_o  = dac_q;
  assign buf_en_o    = (pd_q == 2'b00);
  assign term_1k_o   = (pd_q == 2'b10);
  assign term_100k_o = (pd_q == 2'b11);
  assign rb_hi_o     = {2'b00, pd_q, dac_q[CODE_W-1:6]};
  assign rb_lo_o     = {dac_q[5:0], 2'b00};

  p_commit_only_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_fall_i |=> $stable(dac_q) && $stable(in_q) && $stable(pd_q));

  p_no_half_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fall_i && cnt_q != 2'd2) |=> $stable(dac_q) && $stable(in_q) && $stable(pd_q));

  p_pd_keeps_codes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cmd[3:2] == 2'b01) |=> $stable(dac_q) && $stable(in_q));

  p_ignored_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (cmd[3:2] == 2'b00 || cmd[3:2] == 2'b10))
      |=> $stable(dac_q) && $stable(in_q) && $stable(pd_q));

  p_one_condition_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({buf_en_o, term_1k_o, term_100k_o}));

  p_rb_filler_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rb_hi_o[7:6] == 2'b00 && rb_lo_o[1:0] == 2'b00);
endmodule

// File: tb/dac_cmd_core_tb.sv
`timescale 1ns/1ps
module dac_cmd_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, rx_valid_i = 1'b0, ack_fall_i = 1'b0;
  logic [7:0] rx_byte_i = 8'h00;
  logic [9:0] dac_code_o;
  logic buf_en_o, term_1k_o, term_100k_o;
  logic [7:0] rb_hi_o, rb_lo_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dac_cmd_core dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i), .ack_fall_i(ack_fall_i),
    .dac_code_o(dac_code_o), .buf_en_o(buf_en_o), .term_1k_o(term_1k_o),
    .term_100k_o(term_100k_o), .rb_hi_o(rb_hi_o), .rb_lo_o(rb_lo_o));

  // behavioural reference model
  int m_n = 0, m_b0 = 0, m_b1 = 0, m_in = 0, m_dac = 0, m_pd = 3;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_n = 0; m_in = 0; m_dac = 0; m_pd = 3;
    end else if (start_i || stop_i) begin
      m_n = 0;
    end else if (rx_valid_i && m_n < 2) begin
      if (m_n == 0) m_b0 = int'(rx_byte_i); else m_b1 = int'(rx_byte_i);
      m_n = m_n + 1;
    end else if (ack_fall_i && m_n == 2) begin
      int c, v, old;
      m_n = 0;
      c = m_b0 / 16;
      v = (m_b0 % 16) * 64 + m_b1 / 4;
      old = m_in;
      if (c == 12) begin m_in = v; m_dac = v; end
      else if (c == 13) m_in = v;
      else if (c == 14) begin m_in = v; m_dac = old; end
      else if (c == 15) m_dac = m_in;
      else if (c >= 4 && c <= 7) m_pd = (m_b0 / 4) % 4;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(int'(dac_code_o) == m_dac, "R8 model code", int'(dac_code_o), m_dac);
    chk({buf_en_o, term_1k_o, term_100k_o} ==
        {m_pd == 0, m_pd == 2, m_pd == 3}, "R7 model mode",
        int'({buf_en_o, term_1k_o, term_100k_o}), m_pd);
    chk(int'({rb_hi_o, rb_lo_o}) == (m_pd * 4096 + m_dac * 4), "R10 model readback",
        int'({rb_hi_o, rb_lo_o}), m_pd * 4096 + m_dac * 4);
  end

  task automatic pulse_byte(input logic [7:0] b);
    @(negedge clk); rx_valid_i = 1'b1; rx_byte_i = b;
    @(negedge clk); rx_valid_i = 1'b0;
  endtask
  task automatic pulse_ack;
    @(negedge clk); ack_fall_i = 1'b1;
    @(negedge clk); ack_fall_i = 1'b0;
  endtask
  task automatic pulse_start;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask
  task automatic pulse_stop;
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
  endtask
  task automatic frame(input logic [3:0] c, input logic [9:0] d, input bit st);
    if (st) pulse_start();
    pulse_byte({c, d[9:6]});
    pulse_ack();
    pulse_byte({d[5:0], 2'b00});
    pulse_ack();
  endtask
  task automatic pd_frame(input logic [1:0] m);
    frame(4'b0100, {m, 8'h00}, 1'b1);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dac_code_o == 10'd0, "R1 reset code", int'(dac_code_o), 0);
    chk(term_100k_o && !buf_en_o && !term_1k_o, "R1 reset mode",
        int'({buf_en_o, term_1k_o, term_100k_o}), 1);

    pd_frame(2'b00);
    chk(buf_en_o && !term_1k_o && !term_100k_o, "R7 wake", int'(buf_en_o), 1);
    chk(dac_code_o == 10'd0, "R6 codes kept", int'(dac_code_o), 0);

    frame(4'b1100, 10'h2A5, 1'b1);
    chk(dac_code_o == 10'h2A5, "R2 direct load", int'(dac_code_o), 'h2A5);

    frame(4'b1101, 10'h155, 1'b1);
    chk(dac_code_o == 10'h2A5, "R3 staged only", int'(dac_code_o), 'h2A5);

    frame(4'b1110, 10'h3FF, 1'b1);
    chk(dac_code_o == 10'h155, "R4 old staging moved", int'(dac_code_o), 'h155);

    frame(4'b1111, 10'h000, 1'b1);
    chk(dac_code_o == 10'h3FF, "R5 transfer", int'(dac_code_o), 'h3FF);
    chk(rb_hi_o == 8'h0F && rb_lo_o == 8'hFC, "R10 readback",
        int'({rb_hi_o, rb_lo_o}), 'h0FFC);

    pd_frame(2'b01);
    chk(!buf_en_o && !term_1k_o && !term_100k_o, "R7 floating",
        int'({buf_en_o, term_1k_o, term_100k_o}), 0);
    pd_frame(2'b10);
    chk(term_1k_o && !buf_en_o && !term_100k_o, "R7 1k", int'(term_1k_o), 1);
    frame(4'b1100, 10'h123, 1'b1);
    chk(dac_code_o == 10'h123 && term_1k_o, "R8 load while down", int'(dac_code_o), 'h123);
    chk(rb_hi_o == 8'h24 && rb_lo_o == 8'h8C, "R10 readback mode",
        int'({rb_hi_o, rb_lo_o}), 'h248C);
    pd_frame(2'b11);
    chk(term_100k_o && !buf_en_o, "R7 100k", int'(term_100k_o), 1);
    pd_frame(2'b00);
    chk(buf_en_o && dac_code_o == 10'h123, "R8 retained on wake", int'(dac_code_o), 'h123);

    pulse_start();
    pulse_byte(8'hC3);
    pulse_ack();
    pulse_byte(8'hFC);
    pulse_stop();
    pulse_ack();
    chk(dac_code_o == 10'h123, "R9 stop before ack", int'(dac_code_o), 'h123);
    pulse_start();
    pulse_byte(8'hC3);
    pulse_ack();
    pulse_start();
    chk(dac_code_o == 10'h123, "R9 one byte only", int'(dac_code_o), 'h123);

    frame(4'b0001, 10'h3FF, 1'b1);
    frame(4'b0000, 10'h3FF, 1'b1);
    frame(4'b1010, 10'h3FF, 1'b1);
    chk(dac_code_o == 10'h123 && buf_en_o, "R11 ignored codes", int'(dac_code_o), 'h123);
    frame(4'b1111, 10'h000, 1'b1);
    chk(dac_code_o == 10'h123, "R11 staging untouched", int'(dac_code_o), 'h123);

    frame(4'b1100, 10'h011, 1'b1);
    frame(4'b1101, 10'h222, 1'b0);
    frame(4'b1111, 10'h000, 1'b0);
    chk(dac_code_o == 10'h222, "R12 back-to-back", int'(dac_code_o), 'h222);

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule